// File: doc/BRIEF.md
# Pipelined 3x3 Color Matrix Multiplier

This block multiplies a stream of three-component pixel samples by a programmable 3x3 matrix. On every clock it accepts three signed 12-bit words (A, B, C) and, five clocks later, delivers three signed 12-bit results (X, Y, Z). Each result is a weighted sum of all three inputs. It is used for conversions between component color spaces, for white balance and for colorimetry correction. A chain of several transforms can be folded into a single matrix before it is loaded.

The nine weights are 10-bit signed fractions with nine fraction bits, so a code `k` means `k/512`. They sit in an on-block register bank. One column of three weights is written per clock: the weight for A, the weight for B and the weight for C that all feed the same output. A 2-bit select picks the column, so the whole matrix can be replaced in three clocks while data keeps flowing. Products and sums are carried at full width (23 bits). The result is rounded to 12 bits once, in the last stage.

Top module: `cmx_matrix3`

## Requirements
- R1: Let sA, sB, sC be the input words and wXA..wCZ the weight codes, all read as two's complement. Then X = round((sA·wXA + sB·wXB + sC·wXC)/512), Y uses the Y column and Z uses the Z column in the same way.
- R2: `k_sel` = 1 loads (`k_a`,`k_b`,`k_c`) into the X column, 2 into the Y column and 3 into the Z column, at the clock edge where they are sampled.
- R3: `k_sel` = 0 leaves all nine weights unchanged, whatever is on `k_a`, `k_b` and `k_c`.
- R4: Rounding adds 256 to the 23-bit sum and then drops its 9 low bits. An exact half therefore rounds toward plus infinity (1.5 to 2, -1.5 to -1).
- R5: A sample uses the weights as they stand after the edge that latches it, so a weight written on that same edge already applies to it.
- R6: A sample latched on edge n appears on the outputs after edge n+4, which is five clocks counting the latch edge. `out_vld` follows `in_vld` with the same delay, and a new result leaves every clock.
- R7: Overflow is not flagged. The 12-bit result wraps modulo 4096 (a true +2048 appears as 0x800).
- R8: A synchronous active-high `rst` clears all nine weights, every pipeline register, the outputs and `out_vld`.
- R9: Loading the three columns on three back-to-back clocks and then applying A=B=C=1 yields, on each output, the rounded sum of that column's three weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks the current input sample as valid |
| a_in | input | 12 | Input component A, two's complement |
| b_in | input | 12 | Input component B, two's complement |
| c_in | input | 12 | Input component C, two's complement |
| k_sel | input | 2 | Weight column select: 0 hold, 1 X, 2 Y, 3 Z |
| k_a | input | 10 | Weight applied to A in the selected column |
| k_b | input | 10 | Weight applied to B in the selected column |
| k_c | input | 10 | Weight applied to C in the selected column |
| out_vld | output | 1 | Valid flag delayed to match the results |
| x_out | output | 12 | Output X, two's complement |
| y_out | output | 12 | Output Y, two's complement |
| z_out | output | 12 | Output Z, two's complement |

## Verification
The bench uses a fixed matrix whose three columns behave very differently: an average of A and B, a full-scale negation of A plus 511/512 of C, and a tiny 1/512 weight on every input. Small values of both signs that land on exact halves separate correct rounding from truncation or rounding away from zero. Full-scale positive and negative inputs check the sign handling and the wrap at the output. A weight write placed on the same edge as a sample, and the samples around it, shows exactly which edge a new column takes effect on. A reset in mid-stream, followed by a known sample, shows that the weights and the valid flag are cleared.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  parameter int CMX_DATA_W = 12;
  parameter int CMX_COEF_W = 10;
  parameter int CMX_LANES  = 3;
  parameter int CMX_SEL_W  = 2;

  // Reference dot product on plain integers: scale, round half up, wrap.
  function automatic logic [CMX_DATA_W-1:0] cmx_ref_dot(
    input int s0, input int s1, input int s2,
    input int w0, input int w1, input int w2
  );
    int acc;
    acc = s0 * w0 + s1 * w1 + s2 * w2;
    acc = acc + (1 << (CMX_COEF_W - 2));
    acc = acc >>> (CMX_COEF_W - 1);
    return acc[CMX_DATA_W-1:0];
  endfunction

  function automatic int cmx_sdata(input logic [CMX_DATA_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int cmx_scoef(input logic [CMX_COEF_W-1:0] v);
    return int'($signed(v));
  endfunction

endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank #(
  parameter int LANES  = 3,
  parameter int COEF_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEL_W-1:0]              k_sel,
  input  logic [LANES*COEF_W-1:0]       k_col,
  output logic [LANES*LANES*COEF_W-1:0] coef_flat
);

  localparam int ROW_W = LANES * COEF_W;

  for (genvar r = 0; r < LANES; r++) begin : g_row
    logic             row_wr;
    logic [ROW_W-1:0] row_q;

    // Select value 0 means hold; row r answers to code r+1.
    assign row_wr = (k_sel == SEL_W'(r + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= '0;
      end else if (row_wr) begin
        row_q <= k_col;
      end
    end

    assign coef_flat[r*ROW_W +: ROW_W] = row_q;
  end

endmodule

// File: rtl/cmx_mac_lane.sv
module cmx_mac_lane #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_a,
  input  logic [DATA_W-1:0] d_b,
  input  logic [DATA_W-1:0] d_c,
  input  logic [COEF_W-1:0] w_a,
  input  logic [COEF_W-1:0] w_b,
  input  logic [COEF_W-1:0] w_c,
  output logic [DATA_W-1:0] res_q
);

  localparam int TERMS  = 3;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int FRAC   = COEF_W - 1;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);

  logic [DATA_W-1:0] d_v [TERMS];
  logic [COEF_W-1:0] w_v [TERMS];
  logic signed [PROD_W-1:0] prod_q [TERMS];
  logic [SUM_W-1:0] pair_q;
  logic [SUM_W-1:0] tail_q;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] biased;

  assign d_v[0] = d_a;
  assign d_v[1] = d_b;
  assign d_v[2] = d_c;
  assign w_v[0] = w_a;
  assign w_v[1] = w_b;
  assign w_v[2] = w_c;

  // Stage 2: three signed products at full width.
  for (genvar i = 0; i < TERMS; i++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst) prod_q[i] <= '0;
      else     prod_q[i] <= $signed(d_v[i]) * $signed(w_v[i]);
    end
  end

  // Stage 3: first two products summed, third carried with sign extension.
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= '0;
      tail_q <= '0;
    end else begin
      pair_q <= {prod_q[0][PROD_W-1], prod_q[0]} + {prod_q[1][PROD_W-1], prod_q[1]};
      tail_q <= {prod_q[2][PROD_W-1], prod_q[2]};
    end
  end

  // Stage 4: full-precision sum.
  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= pair_q + tail_q;
  end

  // Stage 5: the single rounding point, result wraps to DATA_W bits.
  assign biased = sum_q + HALF;

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= biased[FRAC +: DATA_W];
  end

endmodule

// File: rtl/cmx_matrix3.sv
module cmx_matrix3
  import cmx_pkg::*;
#(
  parameter int DATA_W = CMX_DATA_W,
  parameter int COEF_W = CMX_COEF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] c_in,
  input  logic [1:0]        k_sel,
  input  logic [COEF_W-1:0] k_a,
  input  logic [COEF_W-1:0] k_b,
  input  logic [COEF_W-1:0] k_c,
  output logic              out_vld,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] z_out
);

  localparam int LANES = 3;
  localparam int DEPTH = 5;
  localparam int ROW_W = LANES * COEF_W;

  logic [LANES*LANES*COEF_W-1:0] coef_flat;
  logic [DATA_W-1:0]             a_q, b_q, c_q;
  logic [DEPTH-1:0]              vld_pipe;
  logic [DATA_W-1:0]             lane_res [LANES];

  cmx_coef_bank #(
    .LANES (LANES),
    .COEF_W(COEF_W),
    .SEL_W (2)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .k_sel    (k_sel),
    .k_col    ({k_c, k_b, k_a}),
    .coef_flat(coef_flat)
  );

  // Stage 1: sample latch, same edge as any weight write.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= c_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_pipe <= '0;
    else     vld_pipe <= {vld_pipe[DEPTH-2:0], in_vld};
  end

  assign out_vld = vld_pipe[DEPTH-1];

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    cmx_mac_lane #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W)
    ) u_lane (
      .clk  (clk),
      .rst  (rst),
      .d_a  (a_q),
      .d_b  (b_q),
      .d_c  (c_q),
      .w_a  (coef_flat[r*ROW_W + 0*COEF_W +: COEF_W]),
      .w_b  (coef_flat[r*ROW_W + 1*COEF_W +: COEF_W]),
      .w_c  (coef_flat[r*ROW_W + 2*COEF_W +: COEF_W]),
      .res_q(lane_res[r])
    );
  end

  assign x_out = lane_res[0];
  assign y_out = lane_res[1];
  assign z_out = lane_res[2];

endmodule

// File: rtl/cmx_matrix3_chk.sv
module cmx_matrix3_chk
  import cmx_pkg::*;
#(
  parameter int DATA_W = CMX_DATA_W,
  parameter int COEF_W = CMX_COEF_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_vld,
  input logic [DATA_W-1:0]       a_in,
  input logic [DATA_W-1:0]       b_in,
  input logic [DATA_W-1:0]       c_in,
  input logic [1:0]              k_sel,
  input logic [COEF_W-1:0]       k_a,
  input logic [COEF_W-1:0]       k_b,
  input logic [COEF_W-1:0]       k_c,
  input logic                    out_vld,
  input logic [DATA_W-1:0]       x_out,
  input logic [DATA_W-1:0]       y_out,
  input logic [DATA_W-1:0]       z_out,
  input logic [9*COEF_W-1:0]     coef_flat
);

  localparam int ROW_W = 3 * COEF_W;

  logic [2:0]        age;
  logic [DATA_W-1:0] outs [3];

  assign outs[0] = x_out;
  assign outs[1] = y_out;
  assign outs[2] = z_out;

  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 3'd7)  age <= age + 3'd1;
  end

  // R3: select 0 keeps the bank frozen.
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (k_sel == 2'd0) |=> (coef_flat == $past(coef_flat)));

  // R6: valid flag trails the input flag by five edges.
  assert_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5) |-> (out_vld == $past(in_vld, 5)));

  // R8: reset leaves weights, flag and outputs at zero.
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!out_vld && coef_flat == '0 && x_out == '0 && y_out == '0 && z_out == '0));

  for (genvar r = 0; r < 3; r++) begin : g_lane_chk
    // R2: the addressed column takes the three port values.
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      (k_sel == 2'(r + 1)) |=> (coef_flat[r*ROW_W +: ROW_W] == $past({k_c, k_b, k_a})));

    // R1, R4, R5, R7: result equals the integer model of the sample
    // latched five edges back with the weights that stood after that edge.
    assert_dot_R1: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd5) |-> (outs[r] == cmx_ref_dot(
        cmx_sdata($past(a_in, 5)), cmx_sdata($past(b_in, 5)), cmx_sdata($past(c_in, 5)),
        cmx_scoef($past(coef_flat[r*ROW_W + 0*COEF_W +: COEF_W], 4)),
        cmx_scoef($past(coef_flat[r*ROW_W + 1*COEF_W +: COEF_W], 4)),
        cmx_scoef($past(coef_flat[r*ROW_W + 2*COEF_W +: COEF_W], 4)))));
  end

endmodule

bind cmx_matrix3 cmx_matrix3_chk #(
  .DATA_W(DATA_W),
  .COEF_W(COEF_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .a_in     (a_in),
  .b_in     (b_in),
  .c_in     (c_in),
  .k_sel    (k_sel),
  .k_a      (k_a),
  .k_b      (k_b),
  .k_c      (k_c),
  .out_vld  (out_vld),
  .x_out    (x_out),
  .y_out    (y_out),
  .z_out    (z_out),
  .coef_flat(coef_flat)
);

// File: tb/cmx_matrix3_bench.sv
module cmx_matrix3_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [11:0] a_in = '0, b_in = '0, c_in = '0;
  logic [1:0]  k_sel = '0;
  logic [9:0]  k_a = '0, k_b = '0, k_c = '0;
  logic        out_vld;
  logic [11:0] x_out, y_out, z_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmx_matrix3 u_cmx_matrix3 (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .k_sel(k_sel), .k_a(k_a), .k_b(k_b), .k_c(k_c),
    .out_vld(out_vld), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  // Matrix used: X = (A+B)/2, Y = -A + 511/512 C, Z = (A+B+C)/512.
  // Columns: a, b, c, expected x, y, z (hand computed, round half up, wrap).
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{   10,    20,    0,    15,   -10,   0},  // R1 R4
    '{    3,     0,    0,     2,    -3,   0},  // R4: 1.5 -> 2
    '{   -3,     0,    0,    -1,     3,   0},  // R4: -1.5 -> -1
    '{ 2047,  2047, 2047,  2047,    -4,  12},  // R1 full scale
    '{-2048, -2048,-2048, -2048,     4, -12},  // R1 negative full scale
    '{-2048,     0,    0, -1024, -2048,  -4},  // R7: +2048 wraps to 0x800
    '{    0,     0, 1000,     0,   998,   2},  // R1
    '{    1,     1,    1,     1,     0,   0}   // R9 impulse
  };

  // Expected-value delay line matching the five-clock latency.
  int    ex [5], ey [5], ez [5];
  logic  ev [5], ec [5];
  string et [5];

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%03h exp=%03h", tag, got, exp);
    end
  endtask

  task automatic step(input int a, input int b, input int c, input logic [1:0] sel,
                      input int wa, input int wb, input int wc, input logic v,
                      input int xx, input int yy, input int zz, input logic en,
                      input string tag);
    @(negedge clk);
    if (ec[4]) begin
      chk({et[4], " X"}, x_out, 12'(ex[4]));
      chk({et[4], " Y"}, y_out, 12'(ey[4]));
      chk({et[4], " Z"}, z_out, 12'(ez[4]));
      chk({et[4], " R6 valid"}, {11'd0, out_vld}, {11'd0, ev[4]});
    end
    for (int i = 4; i > 0; i--) begin
      ex[i] = ex[i-1]; ey[i] = ey[i-1]; ez[i] = ez[i-1];
      ev[i] = ev[i-1]; ec[i] = ec[i-1]; et[i] = et[i-1];
    end
    ex[0] = xx; ey[0] = yy; ez[0] = zz; ev[0] = v; ec[0] = en; et[0] = tag;
    a_in = 12'(a); b_in = 12'(b); c_in = 12'(c);
    k_sel = sel; k_a = 10'(wa); k_b = 10'(wb); k_c = 10'(wc);
    in_vld = v;
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) step(0, 0, 0, 2'd0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b0, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      ex[i] = 0; ey[i] = 0; ez[i] = 0; ev[i] = 0; ec[i] = 0; et[i] = "";
    end
    repeat (3) @(negedge clk);
    // R8: reset state at the ports.
    chk("R8 reset X", x_out, 12'h000);
    chk("R8 reset valid", {11'd0, out_vld}, 12'h000);
    rst = 1'b0;

    // R2 R9: full matrix loaded on three consecutive clocks.
    step(0, 0, 0, 2'd1,  256, 256,   0, 1'b0, 0, 0, 0, 1'b0, "");
    step(0, 0, 0, 2'd2, -512,   0, 511, 1'b0, 0, 0, 0, 1'b0, "");
    step(0, 0, 0, 2'd3,    1,   1,   1, 1'b0, 0, 0, 0, 1'b0, "");

    // Streaming table, one vector per clock.
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][0], VEC[v][1], VEC[v][2], 2'd0, 0, 0, 0, 1'b1,
           VEC[v][3], VEC[v][4], VEC[v][5], 1'b1, $sformatf("R1 vec%0d", v));
    end
    // R6: idle inputs after the stream give zero results with the flag low.
    step(0, 0, 0, 2'd0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b1, "R6 idle");
    step(0, 0, 0, 2'd0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b1, "R6 idle");
    flush();

    // R3: select 0 with noise on the weight ports changes nothing.
    step(0, 0, 0, 2'd0, 341, -300, 77, 1'b0, 0, 0, 0, 1'b0, "");
    step(0, 0, 0, 2'd0, -5, 200, -511, 1'b0, 0, 0, 0, 1'b0, "");
    step(10, 20, 0, 2'd0, 0, 0, 0, 1'b1, 15, -10, 0, 1'b1, "R3 hold");
    flush();

    // R5: a column write on the latch edge already applies to that sample.
    step(3, 0, 0, 2'd0, 0, 0, 0, 1'b1, 2, -3, 0, 1'b1, "R5 before");
    step(3, 0, 0, 2'd1, 0, 0, 0, 1'b1, 0, -3, 0, 1'b1, "R5 same edge");
    step(3, 0, 0, 2'd0, 0, 0, 0, 1'b1, 0, -3, 0, 1'b1, "R5 after");
    flush();

    // R8: reset while data is in flight, then a known sample.
    step(10, 20, 0, 2'd0, 0, 0, 0, 1'b1, 0, 0, 0, 1'b0, "");
    step(10, 20, 0, 2'd0, 0, 0, 0, 1'b1, 0, 0, 0, 1'b0, "");
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 5; i++) ec[i] = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mid reset valid", {11'd0, out_vld}, 12'h000);
    chk("R8 mid reset Y", y_out, 12'h000);
    step(10, 20, 0, 2'd0, 0, 0, 0, 1'b1, 0, 0, 0, 1'b1, "R8 weights cleared");
    flush();

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule